// File: doc/BRIEF.md
# Clock-Synchronous Serial Byte Receiver with Status Flags

This block receives 8-bit frames over a two-wire clocked serial link: a serial clock driven by the far end and a data line. It samples the data line on each rising serial clock edge and fills the frame starting from bit 0. When the eighth bit arrives, the frame moves into a receive data register. A full flag is set at the same time, and an interrupt line can be enabled to follow that flag. The serial clock and data are brought into the system clock domain through a flop synchronizer. Rising edges are found in the system clock domain.

Software reaches the block through a small register port. One control register holds the receive enable and the interrupt enable. A status register holds the full flag, the overrun flag, and copies of the external parity-error and framing-error lines. A read-only register holds the received data. A new frame can complete while the previous one has not yet been collected. In that case the new frame is dropped, the overrun flag is set, and reception freezes. It also freezes while either external error line is high. A halt output tells a neighbouring transmit path that traffic in both directions must stop. A flag clears only when software reads it as 1 and then writes 0 to it.

Top module: `sync_rx_unit`

## Requirements
- R1: Bits are taken on rising serial clock edges. The first bit of a frame lands in data bit 0 and the eighth in bit 7. After eight edges the data register (address 2) holds the frame.
- R2: A frame that completes while the full flag (status bit 0) is 0 sets the full flag and loads the data register.
- R3: A frame that completes while the full flag is 1 sets the overrun flag (status bit 1). The full flag stays 1 and the data register keeps the earlier frame.
- R4: While the overrun flag is 1, serial clock edges are ignored. Reception resumes at bit 0 once the overrun flag is cleared.
- R5: While the parity error input or the framing error input is high, serial clock edges are ignored and the full flag is never set. Status bit 2 reflects the parity input and status bit 3 reflects the framing input.
- R6: Writing 1 to a status flag has no effect. Writing 0 clears a flag only if a status read (address 1) has returned that flag as 1 since the flag was set.
- R7: While the receive enable (control bit 0, address 0) is 0, the bit counter and the partial frame are cleared and serial clock edges are ignored.
- R8: The interrupt output is a level. It is high one cycle after the full flag and the interrupt enable (control bit 1) are both 1, and it drops one cycle after either of them goes to 0.
- R9: After reset, control, status and data read as 0, and the interrupt and halt outputs are 0.
- R10: The halt output is high one cycle after the overrun flag or either error input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the far end |
| sdata | input | 1 | Serial data, sampled on rising sclk |
| par_err | input | 1 | Parity error level, synchronous to clk |
| frm_err | input | 1 | Framing error level, synchronous to clk |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered one cycle after the read strobe |
| rx_irq | output | 1 | Level interrupt request |
| xfer_halt | output | 1 | Stop request for both directions |

## Verification
A rising edge on sclk is seen by the receive logic after the two synchronizer flops and the edge-detect flop. The status and data registers update on the third system edge after the pin changes. The interrupt follows one edge after that, and the halt line follows one edge after the flag that drives it. The bench holds each serial clock phase for six system cycles. It samples only after the trailing low phase of each frame, so every flag has settled before it is read. Register reads return data on the edge that takes the strobe, and the bench samples one time step after that edge.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  localparam int CTRL_EN = 0;
  localparam int CTRL_IE = 1;

  localparam int ST_FULL = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_PAR  = 2;
  localparam int ST_FRM  = 3;
endpackage

// File: rtl/srx_edge_sync.sv
module srx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic sdata_in,
  output logic rise,
  output logic data_s
);
  logic [STAGES-1:0] clk_chain;
  logic [STAGES-1:0] dat_chain;
  logic              clk_last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          clk_chain <= '0;
          dat_chain <= '0;
        end else begin
          clk_chain <= sclk_in;
          dat_chain <= sdata_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          clk_chain <= '0;
          dat_chain <= '0;
        end else begin
          clk_chain <= {clk_chain[STAGES-2:0], sclk_in};
          dat_chain <= {dat_chain[STAGES-2:0], sdata_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) clk_last <= 1'b0;
    else     clk_last <= clk_chain[STAGES-1];
  end

  assign rise   = clk_chain[STAGES-1] & ~clk_last;
  assign data_s = dat_chain[STAGES-1];

  // R1: an edge is reported for a single system cycle
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         hold,
  input  logic         rise,
  input  logic         din,
  output logic         done,
  output logic [W-1:0] frame
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic          take;
  logic          last_bit;

  assign take     = enable & ~hold & rise;
  assign last_bit = (cnt == CW'(W-1));
  assign frame    = {din, sh[W-1:1]};
  assign done     = take & last_bit;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt <= '0;
      sh  <= '0;
    end else if (take) begin
      sh  <= {din, sh[W-1:1]};
      cnt <= last_bit ? '0 : cnt + 1'b1;
    end
  end

  // R4 / R5: a frozen receiver keeps its bit position
  assert_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && hold) |=> $stable(cnt));
  // R7: disabled receiver drops any partial frame
  assert_idle_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt == '0 && sh == '0));
endmodule

// File: rtl/srx_status.sv
module srx_status
  import sync_rx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [W-1:0]      wdata,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic              done,
  input  logic [W-1:0]      frame,
  output logic              rx_en,
  output logic              hold,
  output logic [W-1:0]      rdata,
  output logic              irq,
  output logic              halt_out
);
  logic         ie_q;
  logic         full_q, full_nx;
  logic         ovr_q, ovr_nx;
  logic         full_seen_q, full_seen_nx;
  logic         ovr_seen_q, ovr_seen_nx;
  logic [W-1:0] data_q, data_nx;
  logic         stat_wr, stat_rd, ctrl_wr;
  logic [W-1:0] stat_view;
  logic         unused_wbits;

  assign unused_wbits = ^wdata[W-1:2];
  assign ctrl_wr = wr && (addr == SEL_CTRL);
  assign stat_wr = wr && (addr == SEL_STAT);
  assign stat_rd = rd && (addr == SEL_STAT);
  assign hold    = ovr_q | par_err | frm_err;

  always_comb begin
    stat_view          = '0;
    stat_view[ST_FULL] = full_q;
    stat_view[ST_OVR]  = ovr_q;
    stat_view[ST_PAR]  = par_err;
    stat_view[ST_FRM]  = frm_err;
  end

  always_comb begin
    full_nx = full_q;
    ovr_nx  = ovr_q;
    data_nx = data_q;
    if (done) begin
      if (full_q) ovr_nx = 1'b1;
      else begin
        full_nx = 1'b1;
        data_nx = frame;
      end
    end
    if (stat_wr && !wdata[ST_FULL] && full_seen_q) full_nx = 1'b0;
    if (stat_wr && !wdata[ST_OVR]  && ovr_seen_q)  ovr_nx  = 1'b0;

    full_seen_nx = full_seen_q | (stat_rd & full_q);
    ovr_seen_nx  = ovr_seen_q  | (stat_rd & ovr_q);
    if (!full_nx) full_seen_nx = 1'b0;
    if (!ovr_nx)  ovr_seen_nx  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en       <= 1'b0;
      ie_q        <= 1'b0;
      full_q      <= 1'b0;
      ovr_q       <= 1'b0;
      full_seen_q <= 1'b0;
      ovr_seen_q  <= 1'b0;
      data_q      <= '0;
      rdata       <= '0;
      irq         <= 1'b0;
      halt_out    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        rx_en <= wdata[CTRL_EN];
        ie_q  <= wdata[CTRL_IE];
      end
      full_q      <= full_nx;
      ovr_q       <= ovr_nx;
      full_seen_q <= full_seen_nx;
      ovr_seen_q  <= ovr_seen_nx;
      data_q      <= data_nx;
      irq         <= full_q & ie_q;
      halt_out    <= hold;
      if (rd) begin
        case (addr)
          SEL_CTRL: begin
            rdata          <= '0;
            rdata[CTRL_EN] <= rx_en;
            rdata[CTRL_IE] <= ie_q;
          end
          SEL_STAT: rdata <= stat_view;
          SEL_DATA: rdata <= data_q;
          default:  rdata <= '0;
        endcase
      end
    end
  end

  // R2: a frame into an empty register sets the flag and is stored
  assert_full_on_done_R2: assert property (@(posedge clk) disable iff (rst)
    (done && !full_q) |=> (full_q && data_q == $past(frame)));
  // R3: a frame into a full register is dropped and flagged
  assert_ovr_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (done && full_q && !stat_wr) |=> (ovr_q && full_q && $stable(data_q)));
  // R5: error inputs block the full flag
  assert_err_block_R5: assert property (@(posedge clk) disable iff (rst)
    ((par_err || frm_err) && !full_q) |=> !full_q);
  // R6: a write of 1 never clears the full flag
  assert_one_noeffect_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && wdata[ST_FULL] && full_q) |=> full_q);
  // R8: interrupt follows flag and enable one cycle later
  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    (full_q && ie_q) |=> irq);
  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (rst)
    !(full_q && ie_q) |=> !irq);
endmodule

// File: rtl/sync_rx_unit.sv
module sync_rx_unit
  import sync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rx_irq,
  output logic              xfer_halt
);
  logic              rise, data_s;
  logic              rx_en, hold, done;
  logic [DATA_W-1:0] frame;

  srx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_in(sclk), .sdata_in(sdata),
    .rise(rise), .data_s(data_s)
  );

  srx_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .enable(rx_en), .hold(hold), .rise(rise),
    .din(data_s), .done(done), .frame(frame)
  );

  srx_status #(.W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .par_err(par_err), .frm_err(frm_err),
    .done(done), .frame(frame), .rx_en(rx_en), .hold(hold),
    .rdata(reg_rdata), .irq(rx_irq), .halt_out(xfer_halt)
  );

  // R10: halt follows the error state one cycle later
  assert_halt_R10: assert property (@(posedge clk) disable iff (rst)
    (par_err || frm_err) |=> xfer_halt);
endmodule

// File: tb/sync_rx_unit_bench.sv
module sync_rx_unit_bench;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0, sdata = 1'b0;
  logic       par_err = 1'b0, frm_err = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       rx_irq, xfer_halt;

  int  n_chk = 0, n_bad = 0;
  bit  done_flag = 0;

  always #(CLK_P/2) clk = ~clk;

  sync_rx_unit u_sync_rx_unit (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata),
    .par_err(par_err), .frm_err(frm_err), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_irq(rx_irq), .xfer_halt(xfer_halt)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    tick(1);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdata = b[i]; sclk = 1'b0;
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
    end
    sclk = 1'b0;
    tick(HALF);
  endtask

  task automatic clear_flags(input logic [7:0] keep);
    logic [7:0] v;
    rd(2'd1, v);
    wr(2'd1, keep);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R9 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R9 stat", v, 8'h00);
    rd(2'd2, v); chk("R9 data", v, 8'h00);
    chk("R9 irq", {7'd0, rx_irq}, 8'h00);
    chk("R9 halt", {7'd0, xfer_halt}, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    wr(2'd0, 8'h03);
    send_bits(8'hA5, 8);
    rd(2'd1, v); chk("R2 full", v, 8'h01);
    rd(2'd2, v); chk("R1 data lsb first", v, 8'hA5);
    chk("R8 irq high", {7'd0, rx_irq}, 8'h01);
    wr(2'd1, 8'h00);
    tick(2);
    rd(2'd1, v); chk("R6 cleared after read", v, 8'h00);
    chk("R8 irq low", {7'd0, rx_irq}, 8'h00);
  endtask

  task automatic t_clear_rules;
    logic [7:0] v;
    send_bits(8'h3C, 8);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R6 write0 unread", v, 8'h01);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R6 write1", v, 8'h01);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R6 write0 read", v, 8'h00);
    rd(2'd2, v); chk("R1 data", v, 8'h3C);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    send_bits(8'h11, 8);
    send_bits(8'h22, 8);
    rd(2'd1, v); chk("R3 ovr flag", v, 8'h03);
    rd(2'd2, v); chk("R3 data kept", v, 8'h11);
    chk("R10 halt ovr", {7'd0, xfer_halt}, 8'h01);
    send_bits(8'h44, 8);
    rd(2'd1, v); chk("R4 frozen stat", v, 8'h03);
    wr(2'd1, 8'h02);
    rd(2'd1, v); chk("R4 ovr stays", v, 8'h02);
    send_bits(8'h55, 8);
    rd(2'd1, v); chk("R4 frozen full", v, 8'h02);
    rd(2'd2, v); chk("R4 frozen data", v, 8'h11);
    wr(2'd1, 8'h00);
    tick(2);
    rd(2'd1, v); chk("R4 ovr cleared", v, 8'h00);
    chk("R10 halt low", {7'd0, xfer_halt}, 8'h00);
    send_bits(8'h66, 8);
    rd(2'd2, v); chk("R4 resumed", v, 8'h66);
    clear_flags(8'h00);
  endtask

  task automatic t_errs;
    logic [7:0] v;
    par_err = 1'b1;
    send_bits(8'h77, 8);
    rd(2'd1, v); chk("R5 par", v, 8'h04);
    chk("R10 halt par", {7'd0, xfer_halt}, 8'h01);
    par_err = 1'b0; frm_err = 1'b1;
    send_bits(8'h70, 8);
    rd(2'd1, v); chk("R5 frm", v, 8'h08);
    rd(2'd2, v); chk("R5 data kept", v, 8'h66);
    frm_err = 1'b0;
    send_bits(8'h78, 8);
    rd(2'd2, v); chk("R5 recovered", v, 8'h78);
    clear_flags(8'h00);
  endtask

  task automatic t_disable;
    logic [7:0] v;
    send_bits(8'hFF, 4);
    wr(2'd0, 8'h02);
    send_bits(8'h99, 8);
    rd(2'd1, v); chk("R7 ignored", v, 8'h00);
    wr(2'd0, 8'h03);
    send_bits(8'h0F, 8);
    rd(2'd2, v); chk("R7 fresh frame", v, 8'h0F);
    clear_flags(8'h00);
  endtask

  task automatic t_irq_mask;
    logic [7:0] v;
    wr(2'd0, 8'h01);
    send_bits(8'h5A, 8);
    chk("R8 masked", {7'd0, rx_irq}, 8'h00);
    wr(2'd0, 8'h03);
    tick(2);
    chk("R8 unmasked", {7'd0, rx_irq}, 8'h01);
    wr(2'd0, 8'h01);
    tick(2);
    chk("R8 remasked", {7'd0, rx_irq}, 8'h00);
    rd(2'd0, v); chk("R8 ctrl", v, 8'h01);
    clear_flags(8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_basic();
    t_clear_rules();
    t_overrun();
    t_errs();
    t_disable();
    t_irq_mask();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule